// File: doc/BRIEF.md
# Serial Register and Command Port

This block is a four-wire serial slave through which a host controller reaches the configuration of a radio core. The host opens a transfer by pulling the select line low. Its first byte is a header that names a 6-bit address, chooses read or write, and chooses single or burst access. The address space holds four kinds of target: writable configuration bytes, read-only status bytes, single-byte command strobes, and two byte-wide ports. One port reaches an 8-entry power table. The other reaches the transmit and receive FIFOs.

The serial pins run asynchronously to the system clock. The block brings them into the clock domain through flop chains and detects the serial clock edges there. While the host shifts each header, each strobe and each written data byte in, the block shifts a live status byte out. That byte reports readiness, a 3-bit state code and a FIFO byte count. Strobes leave the block as one-cycle pulses. FIFO traffic leaves it as one-cycle push and pop pulses.

Top module: `spi_cfg_port`

## Requirements
- R1: A header byte is decoded as bit 7 = read (1) or write (0), bit 6 = burst, bits 5:0 = address. A write header to an address below 0x30, followed by one data byte, stores that byte at the address, and it appears on `cfg_o[8*addr +: 8]`.
- R2: While a header, a strobe or a written data byte shifts in, SO returns a status byte, MSB first. Bit 7 is the inverse of `ready_i`. Bits 6:4 are `state_i`. Bits 3:0 are `rx_count_i` when the most recent header had its read bit set, and `tx_free_i` otherwise; after reset the choice is `tx_free_i`.
- R3: The first status bit is on SO before the first rising serial clock edge after select falls. `so_oe_o` is high only while select is low, and `so_o` is 0 whenever `so_oe_o` is low.
- R4: A single access ends after one data byte. With select still low, the next byte is decoded as a new header.
- R5: In a burst, the address starts at the header address and advances by one after every completed data byte, until select rises. A burst read returns consecutive bytes that an earlier burst wrote.
- R6: A header with burst = 0 and address 0x30 to 0x3D is a strobe. It raises `strobe_o[addr-0x30]` for exactly one clock and takes no data byte. The read bit does not change this.
- R7: A header with burst = 1 and address 0x30 to 0x3D reads `status_bank_i[8*(addr-0x30) +: 8]`. Writes to that range change nothing and raise no strobe.
- R8: After reset, configuration byte 0x04 is 0xD3, 0x05 is 0x91, 0x06 is 0xFF, and every other configuration byte is 0x00.
- R9: Each data byte written to address 0x3F gives one one-cycle `tx_push_o` with the byte on `tx_data_o`. The status byte returned while that byte shifts in carries the free count from before it is pushed.
- R10: Each data byte read from address 0x3F returns `rx_data_i` as it stood when the byte began, then gives exactly one `rx_pop_o`. The FIFO order is kept.
- R11: Address 0x3E reaches an 8-entry power table. Its index is 0 whenever select goes low and advances after every data byte. Its contents appear on `pwr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idle low |
| csn_i | input | 1 | Select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | SO drive enable |
| ready_i | input | 1 | Oscillator ready |
| state_i | input | 3 | Current state code for status byte |
| rx_count_i | input | 4 | RX FIFO byte count |
| tx_free_i | input | 4 | TX FIFO free byte count |
| status_bank_i | input | 112 | Read-only status bytes, 14 x 8 |
| strobe_o | output | 14 | One-cycle command strobe pulses |
| tx_push_o | output | 1 | TX FIFO push pulse |
| tx_data_o | output | 8 | TX FIFO push data |
| rx_pop_o | output | 1 | RX FIFO pop pulse |
| rx_data_i | input | 8 | RX FIFO head byte |
| cfg_o | output | 384 | Configuration bytes, 48 x 8 |
| pwr_o | output | 64 | Power table, 8 x 8 |

## Verification
A FIFO push or pop happens just before the status snapshot for the next byte, and both land within one serial bit time. If the free or fill count is sampled in the wrong order, the host sees the count off by one. The bench drives a TX FIFO burst and an RX FIFO burst back to back, and it runs its own free and fill counters from the pulses. Each returned status nibble is judged against those counters, and each pushed byte is judged against a queue of expected bytes on the clock it appears.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] STAT_BASE = 6'h30;
  localparam logic [ADDR_W-1:0] PWR_ADDR  = 6'h3E;
  localparam logic [ADDR_W-1:0] FIFO_ADDR = 6'h3F;

  function automatic logic [7:0] cfg_rst_val(input int idx);
    case (idx)
      4:       return 8'hD3;
      5:       return 8'h91;
      6:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) q[i] <= RST_VAL;
    end else begin
      q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       si_i,
  input  logic       csn_i,
  input  logic [7:0] load_byte_i,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       load_o,
  output logic       so_o
);
  logic       sclk_q, csn_q;
  logic [2:0] bit_cnt;
  logic [7:0] sh_in, sh_out;
  logic       rise, fall, csn_fall;

  assign rise     = sclk_i & ~sclk_q & ~csn_i;
  assign fall     = ~sclk_i & sclk_q & ~csn_i;
  assign csn_fall = csn_q & ~csn_i;
  // next byte is loaded on select fall or on the falling edge closing a byte
  assign load_o      = csn_fall | (fall & (bit_cnt == 3'd0));
  assign byte_done_o = rise & (bit_cnt == 3'd7);
  assign rx_byte_o   = {sh_in[6:0], si_i};
  assign so_o        = sh_out[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      bit_cnt <= '0;
      sh_in   <= '0;
      sh_out  <= '0;
    end else begin
      sclk_q <= sclk_i;
      csn_q  <= csn_i;
      if (csn_i) begin
        bit_cnt <= '0;
      end else if (rise) begin
        sh_in   <= rx_byte_o;
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (load_o)    sh_out <= load_byte_i;
      else if (fall) sh_out <= {sh_out[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs import spi_cfg_pkg::*; #(
  parameter int NUM_CFG = 48,
  parameter int PWR_DEPTH = 8,
  localparam int PWR_IW = $clog2(PWR_DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   cfg_we_i,
  input  logic [PWR_IW-1:0]      pwr_idx_i,
  input  logic                   pwr_we_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             cfg_rd_o,
  output logic [7:0]             pwr_rd_o,
  output logic [NUM_CFG*8-1:0]   cfg_o,
  output logic [PWR_DEPTH*8-1:0] pwr_o
);
  logic [7:0] cfg_q [NUM_CFG];
  logic [7:0] pwr_q [PWR_DEPTH];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[g] <= cfg_rst_val(g);
      else if (cfg_we_i && addr_i == ADDR_W'(g)) cfg_q[g] <= wdata_i;
    end
    assign cfg_o[g*8 +: 8] = cfg_q[g];
  end

  for (genvar g = 0; g < PWR_DEPTH; g++) begin : g_pwr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pwr_q[g] <= '0;
      else if (pwr_we_i && pwr_idx_i == PWR_IW'(g)) pwr_q[g] <= wdata_i;
    end
    assign pwr_o[g*8 +: 8] = pwr_q[g];
  end

  always_comb begin
    cfg_rd_o = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (addr_i == ADDR_W'(i)) cfg_rd_o = cfg_q[i];
  end

  assign pwr_rd_o = pwr_q[pwr_idx_i];
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port import spi_cfg_pkg::*; #(
  parameter int NUM_CFG = 48,
  parameter int NUM_STAT = 14,
  parameter int PWR_DEPTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   csn_i,
  input  logic                   si_i,
  output logic                   so_o,
  output logic                   so_oe_o,
  input  logic                   ready_i,
  input  logic [2:0]             state_i,
  input  logic [3:0]             rx_count_i,
  input  logic [3:0]             tx_free_i,
  input  logic [NUM_STAT*8-1:0]  status_bank_i,
  output logic [NUM_STAT-1:0]    strobe_o,
  output logic                   tx_push_o,
  output logic [7:0]             tx_data_o,
  output logic                   rx_pop_o,
  input  logic [7:0]             rx_data_i,
  output logic [NUM_CFG*8-1:0]   cfg_o,
  output logic [PWR_DEPTH*8-1:0] pwr_o
);
  localparam int PWR_IW = $clog2(PWR_DEPTH);
  localparam logic [ADDR_W-1:0] STAT_END = STAT_BASE + ADDR_W'(NUM_STAT);

  logic [2:0] pins_s;
  logic csn_s, sclk_s, si_s;

  spi_cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i({csn_i, sclk_i, si_i}), .q_o(pins_s)
  );
  assign {csn_s, sclk_s, si_s} = pins_s;

  logic              byte_done, load, so_bit;
  logic [7:0]        rx_byte, tx_byte, status_byte, rd_byte, cfg_rd, pwr_rd, stat_rd;
  logic              in_data, rw_q, burst_q;
  logic [ADDR_W-1:0] addr_q, hdr_addr, stat_off;
  logic [PWR_IW-1:0] pwr_idx;
  logic              hdr_in_stat, data_wr, cfg_we, pwr_we;

  spi_cfg_shifter u_shift (
    .clk_i, .rst_ni, .sclk_i(sclk_s), .si_i(si_s), .csn_i(csn_s),
    .load_byte_i(tx_byte), .byte_done_o(byte_done), .rx_byte_o(rx_byte),
    .load_o(load), .so_o(so_bit)
  );

  assign so_oe_o = ~csn_s;
  assign so_o    = so_oe_o & so_bit;

  assign hdr_addr    = rx_byte[ADDR_W-1:0];
  assign hdr_in_stat = (hdr_addr >= STAT_BASE) && (hdr_addr < STAT_END);
  assign data_wr     = byte_done & in_data & ~rw_q;
  assign cfg_we      = data_wr & (addr_q < ADDR_W'(NUM_CFG));
  assign pwr_we      = data_wr & (addr_q == PWR_ADDR);

  // count nibble follows the direction of the last header
  assign status_byte = {~ready_i, state_i, rw_q ? rx_count_i : tx_free_i};
  assign stat_off    = addr_q - STAT_BASE;

  always_comb begin
    stat_rd = '0;
    for (int i = 0; i < NUM_STAT; i++)
      if (stat_off == ADDR_W'(i)) stat_rd = status_bank_i[i*8 +: 8];
  end

  always_comb begin
    if (addr_q < ADDR_W'(NUM_CFG))                     rd_byte = cfg_rd;
    else if (addr_q == PWR_ADDR)                       rd_byte = pwr_rd;
    else if (addr_q == FIFO_ADDR)                      rd_byte = rx_data_i;
    else if (addr_q >= STAT_BASE && addr_q < STAT_END) rd_byte = stat_rd;
    else                                               rd_byte = '0;
  end

  assign tx_byte = (in_data && rw_q) ? rd_byte : status_byte;

  spi_cfg_regs #(.NUM_CFG(NUM_CFG), .PWR_DEPTH(PWR_DEPTH)) u_regs (
    .clk_i, .rst_ni, .addr_i(addr_q), .cfg_we_i(cfg_we), .pwr_idx_i(pwr_idx),
    .pwr_we_i(pwr_we), .wdata_i(rx_byte), .cfg_rd_o(cfg_rd), .pwr_rd_o(pwr_rd),
    .cfg_o, .pwr_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_data   <= 1'b0;
      rw_q      <= 1'b0;
      burst_q   <= 1'b0;
      addr_q    <= '0;
      pwr_idx   <= '0;
      strobe_o  <= '0;
      tx_push_o <= 1'b0;
      tx_data_o <= '0;
      rx_pop_o  <= 1'b0;
    end else begin
      strobe_o  <= '0;
      tx_push_o <= 1'b0;
      rx_pop_o  <= 1'b0;
      if (csn_s) begin
        in_data <= 1'b0;
        pwr_idx <= '0;
      end else if (byte_done) begin
        if (!in_data) begin
          rw_q    <= rx_byte[7];
          burst_q <= rx_byte[6];
          addr_q  <= hdr_addr;
          if (hdr_in_stat && !rx_byte[6])
            strobe_o <= NUM_STAT'(1) << (hdr_addr - STAT_BASE);
          else
            in_data <= 1'b1;
        end else begin
          if (addr_q == FIFO_ADDR) begin
            if (rw_q) rx_pop_o <= 1'b1;
            else begin
              tx_push_o <= 1'b1;
              tx_data_o <= rx_byte;
            end
          end
          if (addr_q == PWR_ADDR) pwr_idx <= pwr_idx + 1'b1;
          if (!burst_q) in_data <= 1'b0;
          else if (addr_q < PWR_ADDR) addr_q <= addr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(
  parameter int NUM_CFG = 48,
  parameter int NUM_STAT = 14
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 so_o,
  input logic                 so_oe_o,
  input logic [NUM_STAT-1:0]  strobe_o,
  input logic                 tx_push_o,
  input logic                 rx_pop_o,
  input logic [NUM_CFG*8-1:0] cfg_o
);
  assert_strobe_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));
  assert_strobe_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |=> (strobe_o == '0));
  assert_so_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !so_oe_o |-> !so_o);
  assert_push_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |=> !tx_push_o);
  assert_pop_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |=> !rx_pop_o);
  assert_push_pop_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_push_o && rx_pop_o));
  assert_cfg_in_xfer_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(so_oe_o));
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.NUM_CFG(NUM_CFG), .NUM_STAT(NUM_STAT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .so_o(so_o), .so_oe_o(so_oe_o),
  .strobe_o(strobe_o), .tx_push_o(tx_push_o), .rx_pop_o(rx_pop_o), .cfg_o(cfg_o)
);

// File: tb/spi_cfg_port_test.sv
module spi_cfg_port_test;
  localparam int H = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni, sclk, csn, si, so_o, so_oe_o, ready_i;
  logic [2:0] state_i;
  logic [3:0] rx_count_i = '0, tx_free_i = 4'd15;
  logic [111:0] status_bank_i;
  logic [13:0] strobe_o;
  logic tx_push_o, rx_pop_o;
  logic [7:0] tx_data_o, rx_data_i = '0;
  logic [383:0] cfg_o;
  logic [63:0] pwr_o;

  spi_cfg_port uut (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .csn_i(csn), .si_i(si), .so_o, .so_oe_o,
    .ready_i, .state_i, .rx_count_i, .tx_free_i, .status_bank_i, .strobe_o,
    .tx_push_o, .tx_data_o, .rx_pop_o, .rx_data_i, .cfg_o, .pwr_o
  );

  int n_chk = 0, n_err = 0, tx_free_m = 15;
  bit last_rw = 1'b0;
  logic [7:0] rxq[$];
  logic [7:0] exp_push[$];
  int strobe_seen[14];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] st_exp();
    return {~ready_i, state_i, last_rw ? rx_count_i : tx_free_i};
  endfunction

  // reference environment: FIFOs and strobe counters, compared every clock
  always @(posedge clk) begin
    if (rst_ni) begin
      if (tx_push_o) begin
        if (exp_push.size() == 0) chk("R9 unexpected push", 32'(tx_data_o), 32'hFFFF);
        else chk("R9 push data", 32'(tx_data_o), 32'(exp_push.pop_front()));
        tx_free_m--;
      end
      if (rx_pop_o && rxq.size() > 0) void'(rxq.pop_front());
      for (int i = 0; i < 14; i++) strobe_seen[i] += int'(strobe_o[i]);
      if (!so_oe_o && so_o) chk("R3 SO driven while idle", 1, 0);
    end
    tx_free_i  <= 4'(tx_free_m);
    rx_data_i  <= (rxq.size() > 0) ? rxq[0] : 8'h00;
    rx_count_i <= 4'(rxq.size());
  end

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) si = mo[i];
      repeat (H) @(negedge clk);
      mi[i] = so_o;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
  endtask

  task automatic hdr(input string req, input logic [7:0] h);
    logic [7:0] e, r;
    e = st_exp();
    xfer(h, r);
    chk(req, 32'(r), 32'(e));
    last_rw = h[7];
  endtask

  task automatic wr(input string req, input logic [7:0] d);
    logic [7:0] e, r;
    e = st_exp();
    xfer(d, r);
    chk(req, 32'(r), 32'(e));
  endtask

  task automatic rd(input string req, input logic [7:0] e);
    logic [7:0] r;
    xfer(8'h00, r);
    chk(req, 32'(r), 32'(e));
  endtask

  task automatic cs_lo();
    @(negedge clk) csn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_hi();
    @(negedge clk) csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 14; i++) begin
      strobe_seen[i] = 0;
      status_bank_i[i*8 +: 8] = 8'hA0 + 8'(i);
    end
    rst_ni = 1'b0; sclk = 1'b0; csn = 1'b1; si = 1'b0; ready_i = 1'b0; state_i = 3'd5;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    chk("R8 sync high reset", 32'(cfg_o[4*8 +: 8]), 32'hD3);
    chk("R8 sync low reset", 32'(cfg_o[5*8 +: 8]), 32'h91);
    chk("R8 length reset", 32'(cfg_o[6*8 +: 8]), 32'hFF);
    chk("R8 other reset", 32'(cfg_o[16*8 +: 8]), 32'h00);
    chk("R3 SO disabled idle", 32'(so_oe_o), 0);

    // R2 not ready, R1 single write, R4 back-to-back single accesses
    cs_lo();
    chk("R3 SO enabled on select", 32'(so_oe_o), 1);
    hdr("R2 status not ready", 8'h0A);
    wr("R1 status on data", 8'h5A);
    hdr("R4 second header", 8'h0B);
    wr("R4 status on data", 8'hA5);
    cs_hi();
    chk("R1 single write", 32'(cfg_o[10*8 +: 8]), 32'h5A);
    chk("R4 second write", 32'(cfg_o[11*8 +: 8]), 32'hA5);

    // R5 burst write then burst read
    ready_i = 1'b1; state_i = 3'd2;
    cs_lo();
    hdr("R2 status ready", 8'h50);
    wr("R5 burst wr0", 8'h11); wr("R5 burst wr1", 8'h22); wr("R5 burst wr2", 8'h33);
    cs_hi();
    cs_lo();
    hdr("R5 read header", 8'hD0);
    rd("R5 burst rd0", 8'h11); rd("R5 burst rd1", 8'h22); rd("R5 burst rd2", 8'h33);
    cs_hi();
    chk("R5 third byte stored", 32'(cfg_o[18*8 +: 8]), 32'h33);

    // R6 strobes, including one with the read bit
    cs_lo();
    hdr("R6 strobe calib", 8'h33);
    hdr("R6 strobe reset", 8'h30);
    hdr("R6 strobe read-bit", 8'hBD);
    cs_hi();
    chk("R6 pulse 3", 32'(strobe_seen[3]), 1);
    chk("R6 pulse 0", 32'(strobe_seen[0]), 1);
    chk("R6 pulse 13", 32'(strobe_seen[13]), 1);
    chk("R6 no pulse 1", 32'(strobe_seen[1]), 0);

    // R7 status reads and ignored writes
    cs_lo();
    hdr("R7 status header", 8'hFC);
    rd("R7 status 0x3C", 8'hAC); rd("R7 status 0x3D", 8'hAD);
    cs_hi();
    cs_lo();
    hdr("R7 write header", 8'h7C);
    wr("R7 ignored wr", 8'h00); wr("R7 ignored wr", 8'h00);
    cs_hi();
    chk("R7 no strobe from burst", 32'(strobe_seen[12]), 0);
    cs_lo();
    hdr("R7 reread header", 8'hFC);
    rd("R7 unchanged", 8'hAC);
    cs_hi();

    // R9 TX FIFO burst write
    exp_push.push_back(8'h71); exp_push.push_back(8'h72); exp_push.push_back(8'h73);
    cs_lo();
    hdr("R9 fifo header", 8'h7F);
    wr("R9 free before 1st", 8'h71);
    wr("R9 free before 2nd", 8'h72);
    wr("R9 free before 3rd", 8'h73);
    cs_hi();
    chk("R9 three pushes", 32'(tx_free_m), 12);
    chk("R9 queue drained", 32'(exp_push.size()), 0);

    // R10 RX FIFO burst read
    rxq.push_back(8'hC1); rxq.push_back(8'hC2); rxq.push_back(8'hC3); rxq.push_back(8'hC4);
    repeat (3) @(negedge clk);
    cs_lo();
    hdr("R10 fifo header", 8'hFF);
    rd("R10 rx0", 8'hC1); rd("R10 rx1", 8'hC2); rd("R10 rx2", 8'hC3);
    cs_hi();
    chk("R10 one pop per byte", 32'(rxq.size()), 1);

    // R11 power table, status count after a read header (R2)
    cs_lo();
    hdr("R2 rx count nibble", 8'h7E);
    wr("R11 pwr wr0", 8'h03); wr("R11 pwr wr1", 8'h0E);
    wr("R11 pwr wr2", 8'h27); wr("R11 pwr wr3", 8'h8C);
    cs_hi();
    chk("R11 entry 2", 32'(pwr_o[2*8 +: 8]), 32'h27);
    cs_lo();
    hdr("R11 read header", 8'hFE);
    rd("R11 pwr rd0", 8'h03); rd("R11 pwr rd1", 8'h0E);
    rd("R11 pwr rd2", 8'h27); rd("R11 pwr rd3", 8'h8C);
    cs_hi();
    cs_lo();
    hdr("R11 single read header", 8'hBE);
    rd("R11 index restarts", 8'h03);
    cs_hi();

    chk("R8 sync kept", 32'(cfg_o[4*8 +: 8]), 32'hD3);
    finish_run();
  end
endmodule